// File: doc/BRIEF.md
# Configuration Image Header Parser

This block walks a byte-addressable configuration image held in an external memory and works out where the bitstream payload starts and how many frames it holds. The memory is reached through a read port. The block drives an address and a read strobe, and the byte comes back a fixed number of cycles later. Software or a sequencer gives the image length and pulses `start`. When the block finishes, it reports either a finished result (`done`, with the payload offset and the frame count) or a failure (`err`, with a code).

The walk has five steps:

1. An integrity pass streams every byte of the image, one per cycle, through a reflected CRC-CCITT. Only a zero residue lets parsing continue.
2. The parser reads the header-size byte.
3. It reads the count of lookup-table records.
4. It scans the 9-byte records for the payload block and for the block that holds the component size list.
5. It reads the 16-bit component count and adds up the packed 22-bit component sizes.

Before any byte is read, its address is compared with the image length. Streaming the frames out is left to another block.

Top module: `cfg_image_parser`

## Requirements
- R1: After reset, `busy`, `done`, `err` and `rd_en` are all low and `err_code` is 0.
- R2: The first pass reads bytes 0 to len-1 in order through a CRC with polynomial 0x8408 (reflected), initial value 0, least significant bit first. A non-zero final value ends the run with `err` and `err_code` 1.
- R3: The header size H is the byte at offset 24. The record count N is the byte at offset H-1.
- R4: The records are 9 bytes each, starting at offset H. Byte 0 of a record is the block ID and bytes 1 to 4 are a little-endian start offset. The first record with ID 8 supplies `payload_off`, and a later duplicate is ignored.
- R5: The first record with ID 5 gives the start S of the size list. If no record has ID 8, the code is 3. If ID 8 is present but no record has ID 5, the code is 4.
- R6: The component count C is the little-endian 16-bit value at offsets 55 and 56. Component i is the 22-bit field at bit i*22 of the size list, least significant bit first. It is read as 4 little-endian bytes from S + (i*22)/8 and shifted right by (i*22) mod 8. `frame_count` is the sum of the C fields, and it is 0 when C is 0.
- R7: `rd_addr` is always below the image length while `rd_en` is high. Any address the walk needs that is at or past the end, including H-1 when H is 0, ends the run with `err_code` 2.
- R8: `rd_data` is taken exactly RD_LAT cycles after the cycle in which `rd_en` was high. During the CRC pass, `rd_en` stays high on len back-to-back cycles with addresses 0, 1, 2 and so on.
- R9: `done` and `err` are never high together. Each stays high, with the results unchanged, until the next `start`. A `start` pulse while `busy` is high is ignored.
- R10: `err_code` is 0 on success, 1 for a CRC failure, 2 for a bounds failure, 3 for a missing payload block and 4 for a missing size block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a walk; taken only when not busy |
| img_len | input | AW | Image length in bytes, captured at start |
| rd_en | output | 1 | Memory read strobe |
| rd_addr | output | AW | Memory byte address |
| rd_data | input | 8 | Memory byte, RD_LAT cycles after the strobe |
| busy | output | 1 | Walk in progress |
| done | output | 1 | Walk finished without error |
| err | output | 1 | Walk ended in error |
| err_code | output | 3 | Error reason (R10) |
| payload_off | output | 32 | Payload block start offset |
| frame_count | output | FCW | Sum of component sizes |

## Verification
The bench builds the block with AW = 12 and RD_LAT = 3. A 12-bit length keeps every image inside a 4096-byte array, which puts the size list, the records and the end-of-image bounds failures within a few hundred cycles of each other. A read latency of three leaves several bytes in flight during the CRC stream. That exposes any off-by-one in the latency tracking and any byte that is lost or sampled twice. The frame-count width of 40 bits holds several maximum-value 22-bit fields, including a field whose start is not byte-aligned.

// File: rtl/cfg_image_parser.sv
module cfg_image_parser #(
  parameter int AW     = 16,
  parameter int RD_LAT = 2,
  parameter int FCW    = 40
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [AW-1:0]  img_len,
  output logic           rd_en,
  output logic [AW-1:0]  rd_addr,
  input  logic [7:0]     rd_data,
  output logic           busy,
  output logic           done,
  output logic           err,
  output logic [2:0]     err_code,
  output logic [31:0]    payload_off,
  output logic [FCW-1:0] frame_count
);

  localparam int XW = ((AW > 32) ? AW : 32) + 2;
  localparam logic [7:0] ID_PAY  = 8'd8;
  localparam logic [7:0] ID_SIZE = 8'd5;
  localparam int HDR_AT  = 24;
  localparam int CNT_AT  = 55;
  localparam int REC_LEN = 9;
  localparam int FLD_W   = 22;
  localparam logic [2:0] E_CRC = 3'd1, E_OOB = 3'd2, E_NOPAY = 3'd3, E_NOSZ = 3'd4;

  typedef enum logic [3:0] {
    S_IDLE, S_CRC, S_HSZ, S_NREC, S_RID, S_RST, S_NCMP, S_CSZ, S_DONE, S_ERR
  } st_t;

  st_t            st;
  logic           wt;
  logic [AW-1:0]  len_q;
  logic [AW:0]    ia, rc;
  logic [15:0]    crc;
  logic [7:0]     hsz, nrec, rec;
  logic [1:0]     bi;
  logic           tgt, f_pay, f_sz;
  logic [31:0]    word, pstart, cstart;
  logic [15:0]    ncmp, ci;
  logic [FCW-1:0] sum;
  logic [2:0]     code;
  logic [RD_LAT-1:0] vq;

  function automatic logic [15:0] crc_step(input logic [15:0] c_in, input logic [7:0] b);
    logic [15:0] c;
    c = c_in ^ {8'h00, b};
    for (int k = 0; k < 8; k++)
      c = c[0] ? ((c >> 1) ^ 16'h8408) : (c >> 1);
    return c;
  endfunction

  logic [XW-1:0] ra, len_x, rec_base, cbit;
  logic          sgl_st, rd_sgl, dv, rec_last;
  logic [31:0]   word_n, shifted;
  logic [15:0]   crc_n;
  logic [15:0]   ncmp_n;

  assign len_x    = XW'(len_q);
  assign rec_base = XW'(hsz) + XW'(rec) * XW'(REC_LEN);
  assign cbit     = XW'(ci) * XW'(FLD_W);
  assign sgl_st   = (st == S_HSZ) || (st == S_NREC) || (st == S_RID) ||
                    (st == S_RST) || (st == S_NCMP) || (st == S_CSZ);

  always_comb begin
    case (st)
      S_HSZ:   ra = XW'(HDR_AT);
      S_NREC:  ra = XW'(hsz) - XW'(1);
      S_RID:   ra = rec_base;
      S_RST:   ra = rec_base + XW'(1) + XW'(bi);
      S_NCMP:  ra = XW'(CNT_AT) + XW'(bi);
      S_CSZ:   ra = XW'(cstart) + (cbit >> 3) + XW'(bi);
      default: ra = '0;
    endcase
  end

  assign rd_sgl   = sgl_st && !wt && (ra < len_x);
  assign rd_en    = ((st == S_CRC) && (ia < {1'b0, len_q})) || rd_sgl;
  assign rd_addr  = (st == S_CRC) ? ia[AW-1:0] : ra[AW-1:0];
  assign dv       = vq[RD_LAT-1];
  assign word_n   = {rd_data, word[31:8]};
  assign shifted  = word_n >> cbit[2:0];
  assign crc_n    = crc_step(crc, rd_data);
  assign ncmp_n   = {rd_data, ncmp[15:8]};
  assign rec_last = (rec == nrec - 8'd1);

  always_ff @(posedge clk) begin
    if (!rst_n) vq <= '0;
    else        vq <= (vq << 1) | RD_LAT'(rd_en);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; wt <= 1'b0; len_q <= '0; ia <= '0; rc <= '0; crc <= '0;
      hsz <= '0; nrec <= '0; rec <= '0; bi <= '0; tgt <= 1'b0;
      f_pay <= 1'b0; f_sz <= 1'b0; word <= '0; pstart <= '0; cstart <= '0;
      ncmp <= '0; ci <= '0; sum <= '0; code <= '0;
    end else begin
      case (st)
        S_IDLE, S_DONE, S_ERR: begin
          if (start) begin
            len_q <= img_len; ia <= '0; rc <= '0; crc <= '0; code <= '0;
            f_pay <= 1'b0; f_sz <= 1'b0; sum <= '0; wt <= 1'b0; bi <= '0;
            pstart <= '0; cstart <= '0;
            st <= (img_len == '0) ? S_HSZ : S_CRC;
          end
        end
        S_CRC: begin
          if (rd_en) ia <= ia + 1'b1;
          if (dv) begin
            crc <= crc_n;
            rc  <= rc + 1'b1;
            if ((rc + 1'b1) == {1'b0, len_q}) begin
              if (crc_n == 16'h0) st <= S_HSZ;
              else begin st <= S_ERR; code <= E_CRC; end
            end
          end
        end
        default: begin
          if (!wt) begin
            if (ra >= len_x) begin st <= S_ERR; code <= E_OOB; end
            else wt <= 1'b1;
          end else if (dv) begin
            wt <= 1'b0;
            case (st)
              S_HSZ: begin hsz <= rd_data; st <= S_NREC; end
              S_NREC: begin
                nrec <= rd_data; rec <= '0;
                if (rd_data == 8'd0) begin st <= S_ERR; code <= E_NOPAY; end
                else st <= S_RID;
              end
              S_RID: begin
                if (rd_data == ID_PAY && !f_pay) begin
                  tgt <= 1'b0; bi <= '0; word <= '0; st <= S_RST;
                end else if (rd_data == ID_SIZE && !f_sz) begin
                  tgt <= 1'b1; bi <= '0; word <= '0; st <= S_RST;
                end else if (rec_last) begin
                  st <= S_ERR; code <= f_pay ? E_NOSZ : E_NOPAY;
                end else rec <= rec + 8'd1;
              end
              S_RST: begin
                word <= word_n; bi <= bi + 2'd1;
                if (bi == 2'd3) begin
                  if (!tgt) begin pstart <= word_n; f_pay <= 1'b1; end
                  else      begin cstart <= word_n; f_sz  <= 1'b1; end
                  if ((f_pay || !tgt) && (f_sz || tgt)) begin
                    st <= S_NCMP; bi <= '0;
                  end else if (rec_last) begin
                    st <= S_ERR; code <= (f_pay || !tgt) ? E_NOSZ : E_NOPAY;
                  end else begin
                    rec <= rec + 8'd1; st <= S_RID;
                  end
                end
              end
              S_NCMP: begin
                ncmp <= ncmp_n; bi <= bi + 2'd1;
                if (bi == 2'd1) begin
                  bi <= '0; ci <= '0;
                  st <= (ncmp_n == 16'd0) ? S_DONE : S_CSZ;
                end
              end
              S_CSZ: begin
                word <= word_n; bi <= bi + 2'd1;
                if (bi == 2'd3) begin
                  sum <= sum + FCW'(shifted[FLD_W-1:0]);
                  ci  <= ci + 16'd1;
                  if (ci == ncmp - 16'd1) st <= S_DONE;
                end
              end
              default: st <= S_ERR;
            endcase
          end
        end
      endcase
    end
  end

  assign busy        = !((st == S_IDLE) || (st == S_DONE) || (st == S_ERR));
  assign done        = (st == S_DONE);
  assign err         = (st == S_ERR);
  assign err_code    = code;
  assign payload_off = pstart;
  assign frame_count = sum;

  p_rd_inbounds_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> (XW'(rd_addr) < XW'(len_q)));

  p_one_outstanding_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (sgl_st && wt && !dv) |-> !rd_en);

  p_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && err));

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((done || err) && !start) |=> ($stable(err_code) && $stable(frame_count) &&
                                   $stable(payload_off) && $stable(done) && $stable(err)));

  p_busy_ignore_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> $stable(len_q));

  p_code_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (err |-> (err_code >= 3'd1 && err_code <= 3'd4)) and (done |-> err_code == 3'd0));

endmodule

// File: tb/cfg_image_parser_tb.sv
module cfg_image_parser_tb_top;
  localparam int AW = 12;
  localparam int RD_LAT = 3;
  localparam int FCW = 40;
  localparam int MEMSZ = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [AW-1:0] img_len = '0;
  logic rd_en;
  logic [AW-1:0] rd_addr;
  logic [7:0] rd_data;
  logic busy, done, err;
  logic [2:0] err_code;
  logic [31:0] payload_off;
  logic [FCW-1:0] frame_count;

  always #2.5 clk = ~clk;

  cfg_image_parser #(.AW(AW), .RD_LAT(RD_LAT), .FCW(FCW)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .img_len(img_len),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .busy(busy), .done(done), .err(err), .err_code(err_code),
    .payload_off(payload_off), .frame_count(frame_count));

  logic [7:0] mem [MEMSZ];
  logic [7:0] pipe [RD_LAT];
  always @(posedge clk) begin
    pipe[0] <= rd_en ? mem[rd_addr] : 8'hxx;
    for (int k = 1; k < RD_LAT; k++) pipe[k] <= pipe[k-1];
  end
  assign rd_data = pipe[RD_LAT-1];

  int n_tests = 0, n_fail = 0, cyc = 0;
  int cur_len = 0;
  int oob = 0, clash = 0;

  always @(negedge clk) begin
    cyc++;
    if (rst_n && rd_en && int'(rd_addr) >= cur_len) oob++;
    if (done && err) clash++;
    if (busy && (done || err)) clash++;
    if (cyc > 150000) begin
      n_fail++; n_tests++;
      $display("FAIL watchdog: run hung (act cycles %0d, exp < 150000)", cyc);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: act %0d exp %0d", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] crc_ref(input int n);
    logic [15:0] c = 16'h0;
    for (int i = 0; i < n; i++) begin
      c = c ^ {8'h00, mem[i]};
      for (int k = 0; k < 8; k++) c = c[0] ? ((c >> 1) ^ 16'h8408) : (c >> 1);
    end
    return c;
  endfunction

  task automatic fill();
    for (int i = 0; i < MEMSZ; i++) mem[i] = 8'((i * 7 + 3) & 255);
  endtask

  task automatic put32(input int a, input longint v);
    for (int k = 0; k < 4; k++) mem[a+k] = 8'((v >> (8*k)) & 255);
  endtask

  task automatic put_rec(input int h, input int i, input int id, input longint st);
    mem[h + 9*i] = 8'(id);
    put32(h + 9*i + 1, st);
  endtask

  task automatic put_comp(input int base, input int idx, input longint v);
    for (int k = 0; k < 22; k++) begin
      int bit_at;
      bit_at = base*8 + idx*22 + k;
      mem[bit_at/8][bit_at%8] = v[k];
    end
  endtask

  task automatic seal(input int len);
    logic [15:0] c;
    c = crc_ref(len - 2);
    mem[len-2] = c[7:0];
    mem[len-1] = c[15:8];
  endtask

  // Behavioural reference of the whole walk
  task automatic model(input int len, output int code, output longint off, output longint fc);
    longint h, n, cs, nc, a, w;
    bit fp, fs;
    code = 0; off = 0; fc = 0; fp = 0; fs = 0; cs = 0;
    if (len > 0 && crc_ref(len) != 0) begin code = 1; return; end
    if (24 >= len) begin code = 2; return; end
    h = mem[24];
    if (h == 0 || h - 1 >= len) begin code = 2; return; end
    n = mem[h-1];
    for (int i = 0; i < n && !(fp && fs); i++) begin
      a = h + 9*i;
      if (a >= len) begin code = 2; return; end
      if ((mem[a] == 8 && !fp) || (mem[a] == 5 && !fs)) begin
        if (a + 4 >= len) begin code = 2; return; end
        w = 0;
        for (int k = 0; k < 4; k++) w = w | (longint'(mem[a+1+k]) << (8*k));
        if (mem[a] == 8 && !fp) begin fp = 1; off = w; end
        else begin fs = 1; cs = w; end
      end
    end
    if (!fp) begin code = 3; return; end
    if (!fs) begin code = 4; return; end
    if (56 >= len) begin code = 2; return; end
    nc = longint'(mem[55]) | (longint'(mem[56]) << 8);
    for (int c = 0; c < nc; c++) begin
      a = cs + (c*22)/8;
      w = 0;
      for (int k = 0; k < 4; k++) begin
        if (a + k >= len) begin code = 2; return; end
        w = w | (longint'(mem[a+k]) << (8*k));
      end
      fc += (w >> ((c*22) % 8)) & 64'h3FFFFF;
    end
  endtask

  task automatic run(input int len, input string tag, input bit mid_start);
    int ecode; longint eoff, efc; int waitc;
    model(len, ecode, eoff, efc);
    cur_len = len; oob = 0; clash = 0;
    @(negedge clk); img_len = AW'(len); start = 1'b1;
    @(negedge clk); start = 1'b0;
    if (len > 0) begin
      int bad = 0;
      for (int i = 0; i < len; i++) begin
        if (!(rd_en && int'(rd_addr) == i)) bad++;
        if (i < len - 1) @(negedge clk);
      end
      chk(bad == 0, {tag, " R8 R2 crc stream addresses"}, bad, 0);
    end
    waitc = 0;
    while (!(done || err) && waitc < 20000) begin
      @(negedge clk); waitc++;
      if (mid_start && waitc == 10) begin
        img_len = AW'(5); start = 1'b1;
        @(negedge clk); start = 1'b0; img_len = AW'(len);
      end
    end
    chk(err_code == 3'(ecode), {tag, " R10 code"}, err_code, ecode);
    chk((ecode == 0) ? (done && !err) : (err && !done), {tag, " R9 done/err"}, {done, err}, (ecode == 0) ? 2 : 1);
    if (ecode == 0) begin
      chk(payload_off == 32'(eoff), {tag, " R4 payload_off"}, payload_off, eoff);
      chk(frame_count == FCW'(efc), {tag, " R6 frame_count"}, frame_count, efc);
    end
    chk(oob == 0, {tag, " R7 reads in bounds"}, oob, 0);
    chk(clash == 0, {tag, " R9 flag exclusivity"}, clash, 0);
    repeat (4) @(negedge clk);
    chk((err_code == 3'(ecode)) && (done || err), {tag, " R9 result held"}, err_code, ecode);
  endtask

  task automatic base_image(input int len);
    fill();
    mem[24] = 8'd64;
    mem[63] = 8'd3;
    put_rec(64, 0, 2, 500);
    put_rec(64, 1, 8, 300);
    put_rec(64, 2, 5, 200);
    mem[55] = 8'd5; mem[56] = 8'd0;
    for (int i = 0; i < 12; i++) mem[200 + i] = 8'h00;
    put_comp(200, 0, 22'h000123);
    put_comp(200, 1, 22'h3FFFFF);
    put_comp(200, 2, 22'h0ABCDE);
    put_comp(200, 3, 22'h3FFFFF);
    put_comp(200, 4, 22'h000001);
    seal(len);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !done && !err && !rd_en && err_code == 0, "R1 reset state", {busy, done, err, rd_en}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    base_image(400);
    run(400, "T1 R3 R5 nominal", 1'b0);

    base_image(400); mem[10] = mem[10] ^ 8'h04;
    run(400, "T2 R2 crc corrupt", 1'b0);

    base_image(400); mem[64 + 18] = 8'd7; seal(400);
    run(400, "T3 R5 no size block", 1'b0);

    base_image(400); mem[64 + 9] = 8'd9; seal(400);
    run(400, "T4 R5 no payload block", 1'b0);

    base_image(400); put_rec(64, 2, 5, 395); seal(400);
    run(400, "T5 R7 size list past end", 1'b0);

    base_image(400); mem[24] = 8'd0; seal(400);
    run(400, "T6 R7 header size zero", 1'b0);

    base_image(400); mem[55] = 8'd0; mem[56] = 8'd0; seal(400);
    run(400, "T7 R6 zero components", 1'b0);

    base_image(400); put_rec(64, 0, 8, 777); seal(400);
    run(400, "T8 R4 duplicate id first wins", 1'b0);

    base_image(400);
    run(400, "T9 R9 start while busy", 1'b1);

    fill(); seal(20);
    run(20, "T10 R7 short image", 1'b0);

    base_image(600); mem[55] = 8'd3; put_rec(64, 2, 5, 201);
    for (int i = 0; i < 12; i++) mem[201 + i] = 8'h00;
    put_comp(201, 0, 22'h2AAAAA); put_comp(201, 1, 22'h155555); put_comp(201, 2, 22'h3FFFFF);
    seal(600);
    run(600, "T11 R6 R3 shifted list", 1'b0);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule